// File: doc/BRIEF.md
# Next Program Counter Unit

This block keeps the fetch address of a single-cycle processor core. It holds a 32-bit program counter and, on every rising clock edge, loads one of three candidates. The first is the sequential address four bytes on. The second is a PC-relative conditional branch target built from the instruction's 16-bit offset. The third is a pseudo-absolute jump target built from the instruction's 26-bit target field. The current value drives the instruction-memory address. The incremented value is also brought out so that a link path can use it.

Selection happens in two stages. The first stage picks between the sequential address and the branch target. It takes the branch only when the decoder requests a branch and the ALU reports a zero result. The second stage replaces that result with the jump target whenever a jump is requested. A jump therefore wins over a branch that would otherwise be taken. The jump target keeps the four upper bits of the current PC, so a jump stays inside the 256 MB region the jump instruction sits in. Reset is synchronous and clears the counter to zero.

Top module: `npc_unit`

## Requirements
- R1: A high `rst` at a rising clock edge loads `pc_o` with 0x0000_0000. This holds even when branch or jump requests are asserted in the same cycle.
- R2: When `jmp_req` is low and (`br_req` AND `alu_zero`) is false, the next `pc_o` is the current `pc_o` + 4.
- R3: When `br_req` and `alu_zero` are both high and `jmp_req` is low, the next `pc_o` is (`pc_o` + 4) + (sign-extended `instr[15:0]` shifted left by 2).
- R4: A branch request with `alu_zero` low, or `alu_zero` high with no branch request, falls through to `pc_o` + 4.
- R5: When `jmp_req` is high, the next `pc_o` is {`pc_o[31:28]`, `instr[25:0]`, 2'b00}. The upper four bits come from the current PC, not from PC+4.
- R6: A jump request overrides a taken branch in the same cycle.
- R7: `pc_plus4_o` always equals `pc_o` + 4, combinationally.
- R8: After reset, `pc_o[1:0]` stays 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 32 | Current instruction word; offset in [15:0], jump target in [25:0] |
| br_req | input | 1 | Branch request from the decoder |
| alu_zero | input | 1 | ALU zero flag |
| jmp_req | input | 1 | Jump request from the decoder |
| pc_o | output | 32 | Current program counter / fetch address |
| pc_plus4_o | output | 32 | Current program counter plus four |

## Verification
The update path is driven with several patterns, each chosen to tell two behaviours apart:
- Plain sequential steps.
- A branch with both qualifiers high, checked against branches where only one qualifier is high; this exposes a wrong AND in the take condition.
- Backward branches with a small negative offset and with the most negative offset, together with the largest positive offset; these expose a missing or wrong sign extension.
- A jump whose low 16 bits would also make a valid branch offset, applied together with a taken branch; this shows which stage wins.
- A jump taken from the last word of a 256 MB region, where the current PC and PC+4 differ in their upper bits; this shows which one supplies the region.

Reset is asserted together with a jump request to confirm that reset has priority.

// File: rtl/npc_pkg.sv
package npc_pkg;

   typedef enum logic [1:0] {
      NPC_SEQ    = 2'd0,
      NPC_BRANCH = 2'd1,
      NPC_JUMP   = 2'd2
   } npc_src_e;

endpackage

// File: rtl/npc_seq_branch.sv
module npc_seq_branch #(
   parameter int ADDR_W = 32,
   parameter int IMM_W  = 16,
   parameter int SHIFT  = 2
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [IMM_W-1:0]  imm,
   input  logic              take,
   output logic [ADDR_W-1:0] pc_inc,
   output logic [ADDR_W-1:0] stage1
);
   localparam int EXT_W = ADDR_W - IMM_W - SHIFT;
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1) << SHIFT;

   logic [ADDR_W-1:0] offset;

   generate
      if (EXT_W < 1) begin : g_bad_width
         $error("npc_seq_branch: offset does not fit in the address");
      end
      if (SHIFT < 1) begin : g_bad_shift
         $error("npc_seq_branch: SHIFT must be at least 1");
      end
   endgenerate

   assign offset = {{EXT_W{imm[IMM_W-1]}}, imm, {SHIFT{1'b0}}};
   assign pc_inc = pc + STEP;
   assign stage1 = take ? (pc_inc + offset) : pc_inc;

endmodule

// File: rtl/npc_jump_mux.sv
module npc_jump_mux #(
   parameter int ADDR_W = 32,
   parameter int TGT_W  = 26,
   parameter int SHIFT  = 2
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [TGT_W-1:0]  tgt,
   input  logic              jmp,
   input  logic [ADDR_W-1:0] stage1,
   output logic [ADDR_W-1:0] next_pc
);
   localparam int REGION_W = ADDR_W - TGT_W - SHIFT;

   logic [ADDR_W-1:0] jump_addr;

   generate
      if (REGION_W < 0) begin : g_bad_width
         $error("npc_jump_mux: target field wider than the address");
      end else if (REGION_W == 0) begin : g_full
         assign jump_addr = {tgt, {SHIFT{1'b0}}};
      end else begin : g_region
         assign jump_addr = {pc[ADDR_W-1 -: REGION_W], tgt, {SHIFT{1'b0}}};
      end
   endgenerate

   assign next_pc = jmp ? jump_addr : stage1;

endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
   parameter int ADDR_W  = 32,
   parameter int INSTR_W = 32,
   parameter int IMM_W   = 16,
   parameter int TGT_W   = 26,
   parameter int SHIFT   = 2,
   parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [INSTR_W-1:0] instr,
   input  logic               br_req,
   input  logic               alu_zero,
   input  logic               jmp_req,
   output logic [ADDR_W-1:0]  pc_o,
   output logic [ADDR_W-1:0]  pc_plus4_o
);
   import npc_pkg::*;

   localparam int REGION_W = ADDR_W - TGT_W - SHIFT;

   generate
      if (TGT_W > INSTR_W || IMM_W > INSTR_W) begin : g_bad_fields
         $error("npc_unit: instruction fields exceed the instruction width");
      end
      if (REGION_W < 1) begin : g_bad_region
         $error("npc_unit: no region bits left for the jump target");
      end
   endgenerate

   logic [ADDR_W-1:0] pc_q;
   logic [ADDR_W-1:0] stage1;
   logic [ADDR_W-1:0] next_pc;
   logic              br_take;
   npc_src_e          next_src;

   assign br_take = br_req & alu_zero;

   always_comb begin
      if (jmp_req)      next_src = NPC_JUMP;
      else if (br_take) next_src = NPC_BRANCH;
      else              next_src = NPC_SEQ;
   end

   npc_seq_branch #(.ADDR_W(ADDR_W), .IMM_W(IMM_W), .SHIFT(SHIFT)) u_seq_branch (
      .pc     (pc_q),
      .imm    (instr[IMM_W-1:0]),
      .take   (br_take),
      .pc_inc (pc_plus4_o),
      .stage1 (stage1)
   );

   npc_jump_mux #(.ADDR_W(ADDR_W), .TGT_W(TGT_W), .SHIFT(SHIFT)) u_jump_mux (
      .pc      (pc_q),
      .tgt     (instr[TGT_W-1:0]),
      .jmp     (jmp_req),
      .stage1  (stage1),
      .next_pc (next_pc)
   );

   always_ff @(posedge clk) begin
      if (rst) pc_q <= RESET_PC;
      else     pc_q <= next_pc;
   end

   assign pc_o = pc_q;

   // R1: reset wins over every request
   a_r1_reset_load: assert property (@(posedge clk) rst |=> pc_o == RESET_PC);

   // R2: plain step when nothing redirects the flow
   a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
      (next_src == NPC_SEQ) |=> pc_o == $past(pc_o) + (ADDR_W'(1) << SHIFT));

   // R5: a jump keeps the region bits of the current PC
   a_r5_jump_region: assert property (@(posedge clk) disable iff (rst)
      jmp_req |=> pc_o[ADDR_W-1 -: REGION_W] == $past(pc_o[ADDR_W-1 -: REGION_W]));

   // R6: the jump stage wins over a taken branch
   a_r6_jump_wins: assert property (@(posedge clk) disable iff (rst)
      (jmp_req && br_take) |=> pc_o[ADDR_W-REGION_W-1:0] ==
         {$past(instr[TGT_W-1:0]), {SHIFT{1'b0}}});

   // R8: fetch address stays word aligned
   a_r8_aligned: assert property (@(posedge clk) disable iff (rst)
      pc_o[SHIFT-1:0] == '0);

endmodule

// File: tb/npc_unit_bench.sv
module npc_unit_bench;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr = '0;
   logic        br_req = 1'b0;
   logic        alu_zero = 1'b0;
   logic        jmp_req = 1'b0;
   logic [31:0] pc_o;
   logic [31:0] pc_plus4_o;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   npc_unit u_npc_unit (
      .clk(clk), .rst(rst), .instr(instr), .br_req(br_req),
      .alu_zero(alu_zero), .jmp_req(jmp_req),
      .pc_o(pc_o), .pc_plus4_o(pc_plus4_o)
   );

   // fields: instr, br_req, alu_zero, jmp_req, expected next pc
   localparam int NV = 15;
   localparam logic [66:0] VEC [NV] = '{
      {32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h0000_0004},  // R2 step
      {32'h1000_0003, 1'b1, 1'b1, 1'b0, 32'h0000_0014},  // R3 forward taken
      {32'h1000_0003, 1'b1, 1'b0, 1'b0, 32'h0000_0018},  // R4 zero clear
      {32'h1000_0005, 1'b0, 1'b1, 1'b0, 32'h0000_001C},  // R4 no request
      {32'h1000_FFFE, 1'b1, 1'b1, 1'b0, 32'h0000_0018},  // R3 backward -2
      {32'h0800_0100, 1'b0, 1'b0, 1'b1, 32'h0000_0400},  // R5 jump
      {32'h0800_0020, 1'b1, 1'b1, 1'b1, 32'h0000_0080},  // R6 jump beats branch
      {32'h0BFF_FFFF, 1'b0, 1'b0, 1'b1, 32'h0FFF_FFFC},  // R5 to region end
      {32'h0800_0010, 1'b0, 1'b0, 1'b1, 32'h0000_0040},  // R5 region from pc
      {32'h0BFF_FFFF, 1'b0, 1'b0, 1'b1, 32'h0FFF_FFFC},  // R5
      {32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h1000_0000},  // R2 cross region
      {32'h0800_0010, 1'b0, 1'b0, 1'b1, 32'h1000_0040},  // R5 upper region
      {32'h1000_8000, 1'b1, 1'b1, 1'b0, 32'h0FFE_0044},  // R3 most negative
      {32'h1000_7FFF, 1'b1, 1'b1, 1'b0, 32'h1000_0044},  // R3 most positive
      {32'h0000_0000, 1'b0, 1'b0, 1'b0, 32'h1000_0048}   // R2 step
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   initial begin : watchdog
      #2_000_000;
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin : main
      logic [31:0] cur;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset pc", pc_o, 32'h0);
      check("R7 reset pc_plus4", pc_plus4_o, 32'h4);
      rst = 1'b0;
      cur = 32'h0;

      for (int i = 0; i < NV; i++) begin
         {instr, br_req, alu_zero, jmp_req} = VEC[i][66:32];
         #1;
         check("R7 pc_plus4", pc_plus4_o, cur + 32'd4);
         @(posedge clk);
         @(negedge clk);
         check($sformatf("R2/R3/R4/R5/R6 vector %0d", i), pc_o, VEC[i][31:0]);
         check("R8 alignment", {30'h0, pc_o[1:0]}, 32'h0);
         cur = VEC[i][31:0];
      end

      // R1: reset asserted together with a jump and a taken branch
      instr = 32'h0BFF_FFFF; jmp_req = 1'b1; br_req = 1'b1; alu_zero = 1'b1;
      rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R1 reset priority", pc_o, 32'h0);
      check("R7 after reset", pc_plus4_o, 32'h4);

      // R4: branch request alone after reset
      rst = 1'b0; jmp_req = 1'b0; alu_zero = 1'b0; instr = 32'h1000_0040;
      @(posedge clk);
      @(negedge clk);
      check("R4 not taken after reset", pc_o, 32'h4);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule